// File: doc/BRIEF.md
# DMA Read Request Chunk Splitter

The block accepts a read job, given as a start byte address and a byte length, and breaks it into a series of read requests for a host memory read port. Each request carries an address and a byte count. Requests leave through a valid/ready handshake in address order. Together they cover the job exactly, with no gap and no overlap.

Three configuration inputs shape the requests:
- a chunk-size selector;
- a split-mode flag, which keeps requests from crossing 64-byte lines when the address is not 128-byte aligned;
- a cap on how many requests may wait for a completion at the same time.

Each completion pulse frees one outstanding slot. An idle output shows when no job is in progress and no request is outstanding. Software uses it to learn that a job has fully drained.

Top module: `dma_rd_splitter`

## Requirements
- R1: After reset, `idle_o` is 1, `job_ready_o` is 1 and `req_valid_o` is 0.
- R2: The chunk selector encodes the chunk size as 0 = 64 bytes, 1 = 128 bytes, 2 = 256 bytes and 3 = 256 bytes. Without split mode, each request length is the smaller of the chunk size and the bytes still to be requested.
- R3: With split mode on and a request address that is not a multiple of 128, the request length is the smaller of (64 minus the address modulo 64) and the bytes remaining. Such a request never crosses a 64-byte boundary.
- R4: With split mode on and a request address that is a multiple of 128, the request length is the smaller of the chunk size and the bytes remaining.
- R5: The first request address equals the job address. Each following request starts at the previous address plus the previous length. The lengths add up to the job length.
- R6: The outstanding count is the number of request handshakes minus the number of counted completions. It never exceeds the effective limit. `req_valid_o` is high exactly when job bytes remain and the outstanding count is below the limit.
- R7: The effective limit is 12 when the limit field is above 12, and 1 when the field is 0. Otherwise it is the field value.
- R8: A completion pulse arriving while nothing is outstanding is ignored, and the count stays at zero.
- R9: `job_ready_o` is high exactly when no job is active. `idle_o` is high when no job is active and nothing is outstanding. `idle_o` is low in the cycle a job is accepted.
- R10: A job of length 0 is accepted and produces no request.
- R11: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address and length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_max_pend_i | input | PEND_W | Outstanding-request limit field |
| cfg_chunk_sel_i | input | 2 | Chunk size selector |
| cfg_split_i | input | 1 | Split mode enable |
| job_valid_i | input | 1 | Job offered |
| job_ready_o | output | 1 | Job accepted when high together with valid |
| job_addr_i | input | ADDR_W | Job start byte address |
| job_len_i | input | LEN_W | Job byte length |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read port accepts the request |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | 9 | Request byte count |
| cpl_i | input | 1 | One-cycle pulse per returned completion |
| idle_o | output | 1 | No job active and nothing outstanding |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit lengths and a 4-bit limit field with a ceiling of 12. The 16-bit length allows jobs long enough to fill all twelve slots under a slow completion pattern.

The bench sweeps every chunk encoding, both split settings, start offsets on each side of the 64- and 128-byte lines, and lengths from 1 byte up to several chunks. It rotates the limit field through 0, 1, 3, 12 and 15, which covers both clamps. Ready and completion follow fixed patterns, so back-pressure and limit stalls occur in every job.

// File: rtl/dmars_pkg.sv
package dmars_pkg;
  localparam int unsigned CHUNK_W = 9;

  typedef enum logic [1:0] {
    SZ_64   = 2'd0,
    SZ_128  = 2'd1,
    SZ_256  = 2'd2,
    SZ_256X = 2'd3
  } chunk_sel_e;

  function automatic logic [CHUNK_W-1:0] chunk_bytes(input logic [1:0] sel);
    case (chunk_sel_e'(sel))
      SZ_64:   return CHUNK_W'(64);
      SZ_128:  return CHUNK_W'(128);
      default: return CHUNK_W'(256);
    endcase
  endfunction
endpackage

// File: rtl/dmars_chunk_calc.sv
module dmars_chunk_calc
  import dmars_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [6:0]         addr_lo_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [1:0]         size_sel_i,
  input  logic               split_i,
  output logic [CHUNK_W-1:0] len_o
);
  localparam int unsigned CMP_W = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W;

  logic               unaligned;
  logic [CHUNK_W-1:0] cap;
  logic [CMP_W-1:0]   rem_x;
  logic [CMP_W-1:0]   cap_x;

  always_comb begin
    unaligned = split_i && (addr_lo_i != 7'd0);
    // unaligned under split: stop at the next 64-byte line
    cap   = unaligned ? (CHUNK_W'(64) - CHUNK_W'(addr_lo_i[5:0]))
                      : chunk_bytes(size_sel_i);
    rem_x = CMP_W'(rem_i);
    cap_x = CMP_W'(cap);
    len_o = (rem_x < cap_x) ? CHUNK_W'(rem_x) : cap;
  end
endmodule

// File: rtl/dmars_pend_ctr.sv
module dmars_pend_ctr #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned MAX_PEND = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_cfg_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             room_o
);
  logic [CNT_W-1:0] limit;
  logic             dec_ok;

  always_comb begin
    if (limit_cfg_i == '0)                     limit = CNT_W'(1);
    else if (limit_cfg_i > CNT_W'(MAX_PEND))   limit = CNT_W'(MAX_PEND);
    else                                       limit = limit_cfg_i;
  end

  assign dec_ok = dec_i && (count_o != '0);
  assign room_o = count_o < limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else begin
      case ({inc_i, dec_ok})
        2'b10:   count_o <= count_o + CNT_W'(1);
        2'b01:   count_o <= count_o - CNT_W'(1);
        default: count_o <= count_o;
      endcase
    end
  end

  a_r6_pend_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(MAX_PEND));
  a_r6_issue_with_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> room_o);
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) && dec_i && !inc_i |=> count_o == '0);
endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter
  import dmars_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned MAX_PEND = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PEND_W-1:0]  cfg_max_pend_i,
  input  logic [1:0]         cfg_chunk_sel_i,
  input  logic               cfg_split_i,
  input  logic               job_valid_i,
  output logic               job_ready_o,
  input  logic [ADDR_W-1:0]  job_addr_i,
  input  logic [LEN_W-1:0]   job_len_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [CHUNK_W-1:0] req_len_o,
  input  logic               cpl_i,
  output logic               idle_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              job_fire;
  logic              req_fire;
  logic              room;
  logic [PEND_W-1:0] pend_cnt;
  logic [CHUNK_W-1:0] chunk;

  dmars_chunk_calc #(.LEN_W(LEN_W)) i_chunk (
    .addr_lo_i  (addr_q[6:0]),
    .rem_i      (rem_q),
    .size_sel_i (cfg_chunk_sel_i),
    .split_i    (cfg_split_i),
    .len_o      (chunk)
  );

  dmars_pend_ctr #(.CNT_W(PEND_W), .MAX_PEND(MAX_PEND)) i_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .limit_cfg_i (cfg_max_pend_i),
    .inc_i       (req_fire),
    .dec_i       (cpl_i),
    .count_o     (pend_cnt),
    .room_o      (room)
  );

  assign job_ready_o = !busy_q;
  assign job_fire    = job_valid_i && !busy_q;
  assign req_valid_o = busy_q && room;
  assign req_fire    = req_valid_o && req_ready_i;
  assign req_addr_o  = addr_q;
  assign req_len_o   = chunk;
  assign idle_o      = !busy_q && (pend_cnt == '0) && !job_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else if (job_fire) begin
      busy_q <= (job_len_i != '0);
      addr_q <= job_addr_i;
      rem_q  <= job_len_i;
    end else if (req_fire) begin
      addr_q <= addr_q + ADDR_W'(chunk);
      rem_q  <= rem_q - LEN_W'(chunk);
      if (rem_q == LEN_W'(chunk)) busy_q <= 1'b0;
    end
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));
  a_r3_no_line_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && cfg_split_i && (req_addr_o[6:0] != 7'd0)
      |-> ({3'b000, req_addr_o[5:0]} + req_len_o) <= CHUNK_W'(64));
  a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && (req_len_o <= CHUNK_W'(256)));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !req_valid_o && job_ready_o);
  a_r10_empty_job: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_i && job_ready_o && (job_len_i == '0) |=> !req_valid_o && job_ready_o);
endmodule

// File: tb/test_dma_rd_splitter.sv
module test_dma_rd_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_pend = 4'd1;
  logic [1:0]  cfg_sel = 2'd0;
  logic        cfg_split = 1'b0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic [31:0] job_addr = '0;
  logic [15:0] job_len = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [8:0]  req_len;
  logic        cpl = 1'b0;
  logic        idle;

  int checks = 0;
  int fails = 0;
  int tick = 0;

  always #4 clk = ~clk;

  dma_rd_splitter i_dma_rd_splitter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_max_pend_i(cfg_pend),
    .cfg_chunk_sel_i(cfg_sel), .cfg_split_i(cfg_split),
    .job_valid_i(job_valid), .job_ready_o(job_ready),
    .job_addr_i(job_addr), .job_len_i(job_len),
    .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_addr_o(req_addr), .req_len_o(req_len),
    .cpl_i(cpl), .idle_o(idle)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_len(input int a, input int rem, input int sel, input bit sp);
    int c;
    c = (sel == 0) ? 64 : (sel == 1) ? 128 : 256;
    if (sp && (a % 128) != 0) c = 64 - (a % 64);
    return (rem < c) ? rem : c;
  endfunction

  task automatic run_job(input int a, input int l);
    int ea, er, outst, cyc, lim, el;
    bit rdy, cp, ev;
    string tag;
    ea = a; er = l; outst = 0; cyc = 0;
    lim = (cfg_pend == 0) ? 1 : (cfg_pend > 12 ? 12 : int'(cfg_pend));
    @(negedge clk);
    job_valid = 1'b1; job_addr = a; job_len = l; req_ready = 1'b0; cpl = 1'b0;
    #1;
    chk(job_ready == 1'b1, "R9 ready before accept", job_ready, 1);
    chk(idle == 1'b0, "R9 idle drops on accept", idle, 0);
    @(negedge clk);
    job_valid = 1'b0;
    while ((er > 0 || outst > 0) && cyc < 5000) begin
      rdy = (tick % 4) != 3;
      cp  = (outst > 0) && (tick % 5 == 0);
      tick++;
      req_ready = rdy; cpl = cp;
      #1;
      ev = (er > 0) && (outst < lim);
      chk(req_valid == ev, "R6 R7 R11 valid", req_valid, ev);
      chk(idle == 1'b0, "R9 busy not idle", idle, 0);
      chk(job_ready == (er == 0), "R9 ready while active", job_ready, (er == 0));
      if (ev && req_valid) begin
        el = model_len(ea, er, cfg_sel, cfg_split);
        if (cfg_split && (ea % 128) != 0) tag = "R3 len";
        else if (cfg_split) tag = "R4 len";
        else tag = "R2 len";
        chk(req_addr == 32'(ea), "R5 addr", req_addr, ea);
        chk(int'(req_len) == el, tag, req_len, el);
        if (rdy) begin
          ea += el; er -= el; outst++;
        end
      end
      if (cp) outst--;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 5000) chk(1'b0, "R6 job watchdog", cyc, 5000);
    req_ready = 1'b0; cpl = 1'b0;
    #1;
    chk(idle == 1'b1 && req_valid == 1'b0 && job_ready == 1'b1, "R9 idle after drain", idle, 1);
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "global watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int offs[10] = '{0, 8, 60, 63, 64, 100, 127, 128, 192, 250};
    int lens[6]  = '{1, 63, 64, 65, 200, 513};
    int pends[5] = '{0, 1, 3, 12, 15};
    int k;
    #1;
    chk(idle == 1'b1, "R1 idle in reset", idle, 1);
    chk(req_valid == 1'b0, "R1 no request in reset", req_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1 && job_ready == 1'b1 && req_valid == 1'b0, "R1 after reset", idle, 1);

    // R8: stray completions while empty
    cpl = 1'b1;
    repeat (2) @(negedge clk);
    cpl = 1'b0;
    #1;
    chk(idle == 1'b1, "R8 stray completion keeps idle", idle, 1);
    cfg_pend = 4'd1; cfg_sel = 2'd0; cfg_split = 1'b0;
    run_job(0, 256);

    // R10: zero length
    run_job(64, 0);
    @(negedge clk); #1;
    chk(req_valid == 1'b0 && idle == 1'b1, "R10 empty job no request", req_valid, 0);

    // R7: clamps, long jobs reach the ceiling
    cfg_pend = 4'd15; run_job(4, 3000);
    cfg_pend = 4'd0;  run_job(4, 600);

    k = 0;
    for (int s = 0; s < 4; s++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int o = 0; o < 10; o++) begin
          for (int n = 0; n < 6; n++) begin
            cfg_sel = 2'(s); cfg_split = sp[0]; cfg_pend = 4'(pends[k % 5]);
            k++;
            run_job(4096 + offs[o], lens[n]);
          end
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule